// File: doc/BRIEF.md
# Preemptive Interrupt Priority Controller

This block stands between a bank of level-sensitive maskable interrupt request lines and a processor core. Every request slot owns a two-bit software level, held in a small set of writable level registers. Each clock cycle the block picks one pending request to offer the core, as a slot index with a valid flag. It also decides whether that request may preempt the service routine now running on the core.

The core accepts the offered request with an acknowledge pulse and ends a routine with a return pulse. On acknowledge the level of the accepted slot is pushed onto a nesting stack and sets the new threshold. On return the stack pops and the previous threshold comes back. The stack is a three-state machine. `S_IDLE` means no routine is active. `S_NEST` means one to three routines are active. `S_FULL` means every stack entry is used. The transitions are: push (`S_IDLE`→`S_NEST`, `S_NEST`→`S_NEST`, `S_NEST`→`S_FULL` on the last entry), pop (`S_FULL`→`S_NEST`, `S_NEST`→`S_NEST`, `S_NEST`→`S_IDLE` on the last entry), and hold (no push or pop, or a return while in `S_IDLE`).

With the controller switched off, the software levels play no part and the fixed slot order alone picks the winner. Slot order is also the tie-break when the controller is on.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset every level field reads 2'b11 (each level register reads 16'hFFFF), the nesting depth is 0, the threshold output is 0 and no vector is offered.
- R2: Only slots 0 to 21 are real sources. Slots 22 to 31 are never offered, whatever their request inputs do.
- R3: While `gie` is low, `vec_valid` is low.
- R4: With `ctrl_en` high, the offered slot is an eligible pending slot with the highest software level. Level 2'b11 is the highest and 2'b00 the lowest.
- R5: Among eligible slots of equal software level, the highest slot index wins.
- R6: With `ctrl_en` high, a slot is eligible only if its level + 1 is greater than `cur_thr`. A pending slot with a lower or equal level is held back until the threshold drops.
- R7: An acknowledge while `vec_valid` is high pushes the offered slot's level. After the next edge `nest_depth` is one higher and `cur_thr` is that level + 1. A return pops the stack, and `cur_thr` becomes the previous entry + 1, or 0 when the stack is empty.
- R8: With `ctrl_en` low, levels and threshold are ignored and the highest pending slot index is offered.
- R9: Stack limits. While the stack holds 4 entries, nothing is offered. A return at depth 0 is ignored. An acknowledge while `vec_valid` is low is ignored. A return and an acknowledge in the same cycle act as a return only.
- R10: Writing level register k sets slot 8k+j's level from bits [2j+1:2j] of the write data. The new levels take part in arbitration from the next cycle on. `lvl_rd_data` shows the register picked by `lvl_rd_sel`.
- R11: Request inputs are registered. A change on `irq_req` shows on `vec_valid`/`vec_idx` after the next rising edge. `gie` and `ctrl_en` act in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Enables software-level arbitration and threshold gating |
| gie | input | 1 | Core global interrupt enable |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_sel | input | 2 | Level register picked for writing |
| lvl_wr_data | input | 16 | Level register write data, eight 2-bit fields |
| lvl_rd_sel | input | 2 | Level register picked for reading |
| lvl_rd_data | output | 16 | Contents of the register picked for reading |
| irq_req | input | 32 | Request lines, one per slot |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_ret | input | 1 | Core returns from the current routine |
| vec_valid | output | 1 | A vector is offered |
| vec_idx | output | 5 | Offered slot index |
| cur_thr | output | 3 | Current threshold: 0 idle, otherwise top level + 1 |
| nest_depth | output | 3 | Number of stacked routines |

## Verification
The arbiter is driven with requests that land only on the unused slots, all slots at one level, mixed levels, and a ladder of levels 0 to 3. These separate level ranking from slot-order tie-breaking, and both from the dead-slot mask. Acknowledge and return sequences climb the stack to full and unwind it again, including stray returns and acknowledges with nothing offered. These show whether the threshold is compared strictly and whether it is restored correctly. A long random mix of requests, level writes, enable toggles and handshakes, run with the controller both on and off, is compared against a behavioural model on every cycle.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
    typedef logic [1:0] lvl_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_NEST = 2'd1,
        S_FULL = 2'd2
    } nest_st_e;
endpackage

// File: rtl/irqarb_level_regs.sv
module irqarb_level_regs
    import irqarb_pkg::*;
#(
    parameter int NUM_SLOTS     = 32,
    parameter int SLOTS_PER_REG = 8,
    localparam int NUM_REGS     = NUM_SLOTS / SLOTS_PER_REG,
    localparam int REG_W        = SLOTS_PER_REG * 2,
    localparam int SEL_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [REG_W-1:0]       rd_data,
    output logic [NUM_SLOTS*2-1:0] lvl_flat
);
    logic [REG_W-1:0] regs_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) regs_q[k] <= '1;
        end else if (wr_en) begin
            regs_q[wr_sel] <= wr_data;
        end
    end

    assign rd_data = regs_q[rd_sel];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_flat
        assign lvl_flat[k*REG_W +: REG_W] = regs_q[k];
    end

    // R10: a write lands in the selected register
    p_wr_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
    import irqarb_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_SRC   = 22,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   gie,
    input  logic                   blocked,
    input  logic [NUM_SLOTS-1:0]   req_q,
    input  logic [NUM_SLOTS*2-1:0] lvl_flat,
    input  logic [2:0]             thr,
    output logic                   valid,
    output logic [IDX_W-1:0]       idx,
    output lvl_t                   win_lvl
);
    logic             found;
    lvl_t             best_key;
    logic [IDX_W-1:0] best_idx;

    always_comb begin
        lvl_t lv;
        lvl_t key;
        logic elig;
        found    = 1'b0;
        best_key = '0;
        best_idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            lv   = lvl_flat[2*i +: 2];
            key  = en ? lv : 2'd0;
            elig = req_q[i] && (!en || (({1'b0, lv} + 3'd1) > thr));
            if (elig && (!found || key >= best_key)) begin
                found    = 1'b1;
                best_key = key;
                best_idx = IDX_W'(i);
            end
        end
    end

    assign valid   = gie && found && !blocked;
    assign idx     = best_idx;
    assign win_lvl = lvl_flat[2*best_idx +: 2];

    // R3: nothing offered without global enable
    p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !valid);
    // R9: full stack blocks any offer
    p_full_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !valid);
endmodule

// File: rtl/irqarb_nest_stack.sv
module irqarb_nest_stack
    import irqarb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int DEP_W = $clog2(DEPTH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  lvl_t             push_lvl,
    input  logic             pop,
    output logic [DEP_W-1:0] depth,
    output logic [2:0]       thr,
    output logic             full
);
    nest_st_e         st_q, st_n;
    logic [DEP_W-1:0] ptr_q;
    lvl_t             stk_q [DEPTH];
    logic [AW-1:0]    top_a;

    // next-state process
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            S_IDLE: if (push) st_n = (DEPTH == 1) ? S_FULL : S_NEST;
            S_NEST: begin
                if (pop)       st_n = (ptr_q == DEP_W'(1)) ? S_IDLE : S_NEST;
                else if (push) st_n = (ptr_q == DEP_W'(DEPTH - 1)) ? S_FULL : S_NEST;
            end
            S_FULL: if (pop) st_n = (DEPTH == 1) ? S_IDLE : S_NEST;
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_n;
    end

    // stack storage and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int k = 0; k < DEPTH; k++) stk_q[k] <= '0;
        end else if (pop && st_q != S_IDLE) begin
            ptr_q <= ptr_q - DEP_W'(1);
        end else if (push && st_q != S_FULL) begin
            stk_q[AW'(ptr_q)] <= push_lvl;
            ptr_q <= ptr_q + DEP_W'(1);
        end
    end

    assign top_a = AW'(ptr_q - DEP_W'(1));

    // output process
    always_comb begin
        unique case (st_q)
            S_IDLE:  thr = 3'd0;
            default: thr = {1'b0, stk_q[top_a]} + 3'd1;
        endcase
        full  = (st_q == S_FULL);
        depth = ptr_q;
    end

    // R7: accepted push deepens the stack and raises the threshold
    p_push_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q != S_FULL) |=> depth == $past(depth) + DEP_W'(1));
    p_push_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q != S_FULL) |=> thr == {1'b0, $past(push_lvl)} + 3'd1);
    // R7: pop shrinks the stack
    p_pop_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && depth != '0) |=> depth == $past(depth) - DEP_W'(1));
    // R9: return while idle is ignored
    p_idle_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && depth == '0) |=> depth == '0 && thr == 3'd0);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irqarb_pkg::*;
#(
    parameter int NUM_SLOTS     = 32,
    parameter int NUM_SRC       = 22,
    parameter int SLOTS_PER_REG = 8,
    parameter int DEPTH         = 4,
    localparam int NUM_REGS     = NUM_SLOTS / SLOTS_PER_REG,
    localparam int REG_W        = SLOTS_PER_REG * 2,
    localparam int SEL_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int IDX_W        = $clog2(NUM_SLOTS),
    localparam int DEP_W        = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_en,
    input  logic                 gie,
    input  logic                 lvl_wr_en,
    input  logic [SEL_W-1:0]     lvl_wr_sel,
    input  logic [REG_W-1:0]     lvl_wr_data,
    input  logic [SEL_W-1:0]     lvl_rd_sel,
    output logic [REG_W-1:0]     lvl_rd_data,
    input  logic [NUM_SLOTS-1:0] irq_req,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 vec_valid,
    output logic [IDX_W-1:0]     vec_idx,
    output logic [2:0]           cur_thr,
    output logic [DEP_W-1:0]     nest_depth
);
    logic [NUM_SLOTS-1:0]   src_mask;
    logic [NUM_SLOTS-1:0]   req_q;
    logic [NUM_SLOTS*2-1:0] lvl_flat;
    logic                   full;
    logic                   push;
    lvl_t                   win_lvl;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
        assign src_mask[i] = (i < NUM_SRC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= irq_req & src_mask;
    end

    irqarb_level_regs #(
        .NUM_SLOTS     (NUM_SLOTS),
        .SLOTS_PER_REG (SLOTS_PER_REG)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lvl_wr_en),
        .wr_sel   (lvl_wr_sel),
        .wr_data  (lvl_wr_data),
        .rd_sel   (lvl_rd_sel),
        .rd_data  (lvl_rd_data),
        .lvl_flat (lvl_flat)
    );

    irqarb_select #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_SRC   (NUM_SRC)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_en),
        .gie      (gie),
        .blocked  (full),
        .req_q    (req_q),
        .lvl_flat (lvl_flat),
        .thr      (cur_thr),
        .valid    (vec_valid),
        .idx      (vec_idx),
        .win_lvl  (win_lvl)
    );

    assign push = irq_ack && vec_valid && !irq_ret;

    irqarb_nest_stack #(
        .DEPTH (DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_lvl (win_lvl),
        .pop      (irq_ret),
        .depth    (nest_depth),
        .thr      (cur_thr),
        .full     (full)
    );

    // R2: dead slots never offered
    p_dead_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> int'(vec_idx) < NUM_SRC);
    // R6: offered level strictly above the stack threshold when enabled
    p_above_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && vec_valid) |-> ({1'b0, win_lvl} + 3'd1) > cur_thr);
    // R9: stack depth never exceeds its size
    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(nest_depth) <= DEPTH);
endmodule

// File: tb/irq_level_arbiter_tb_top.sv
module irq_level_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b0;
    logic        gie = 1'b0;
    logic        lvl_wr_en = 1'b0;
    logic [1:0]  lvl_wr_sel = '0;
    logic [15:0] lvl_wr_data = '0;
    logic [1:0]  lvl_rd_sel = '0;
    logic [15:0] lvl_rd_data;
    logic [31:0] irq_req = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        vec_valid;
    logic [4:0]  vec_idx;
    logic [2:0]  cur_thr;
    logic [2:0]  nest_depth;

    int    checks = 0;
    int    bad = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    irq_level_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .gie(gie),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_sel(lvl_wr_sel), .lvl_wr_data(lvl_wr_data),
        .lvl_rd_sel(lvl_rd_sel), .lvl_rd_data(lvl_rd_data),
        .irq_req(irq_req), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .vec_valid(vec_valid), .vec_idx(vec_idx), .cur_thr(cur_thr), .nest_depth(nest_depth)
    );

    // behavioural reference model
    int mlvl [32];
    int mstk [$];
    bit [31:0] mreq;

    function automatic int mthr();
        return (mstk.size() == 0) ? 0 : mstk[mstk.size()-1] + 1;
    endfunction

    function automatic void mwin(output bit v, output int idx, output int lv);
        bit f = 0;
        int bk = 0;
        idx = 0;
        for (int i = 0; i < 32; i++) begin
            int key = ctrl_en ? mlvl[i] : 0;
            bit el = mreq[i] && (!ctrl_en || (mlvl[i] + 1 > mthr()));
            if (el && (!f || key >= bk)) begin
                f = 1; bk = key; idx = i;
            end
        end
        lv = mlvl[idx];
        v = gie && f && (mstk.size() < 4);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mlvl[i] = 3;
            mstk.delete();
            mreq = '0;
        end else begin
            bit v; int idx; int lv;
            mwin(v, idx, lv);
            if (irq_ret) begin
                if (mstk.size() > 0) void'(mstk.pop_back());
            end else if (irq_ack && v) begin
                mstk.push_back(lv);
            end
            if (lvl_wr_en)
                for (int j = 0; j < 8; j++) mlvl[8*lvl_wr_sel + j] = int'(lvl_wr_data[2*j +: 2]);
            mreq = irq_req & 32'h003F_FFFF;
        end
    end

    task automatic do_check();
        bit v; int idx; int lv;
        logic [15:0] erd;
        if (!rst_n) return;
        mwin(v, idx, lv);
        for (int j = 0; j < 8; j++) erd[2*j +: 2] = 2'(mlvl[8*lvl_rd_sel + j]);
        checks++;
        if (vec_valid !== v || (v && int'(vec_idx) != idx) || int'(cur_thr) != mthr()
            || int'(nest_depth) != mstk.size() || lvl_rd_data !== erd) begin
            bad++;
            $display("FAIL %s t=%0t act v=%0b i=%0d thr=%0d d=%0d rd=%h exp v=%0b i=%0d thr=%0d d=%0d rd=%h",
                     tag, $time, vec_valid, vec_idx, cur_thr, nest_depth, lvl_rd_data,
                     v, idx, mthr(), mstk.size(), erd);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            do_check();
        end
    endtask

    task automatic wr_lvl(logic [1:0] sel, logic [15:0] data);
        lvl_wr_en = 1'b1; lvl_wr_sel = sel; lvl_wr_data = data;
        step(1);
        lvl_wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0; step(1);
    endtask

    task automatic pulse_ret();
        irq_ret = 1'b1; step(1); irq_ret = 1'b0; step(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents read 16'hFFFF, idle stack
        tag = "R1";
        for (int k = 0; k < 4; k++) begin
            lvl_rd_sel = 2'(k);
            step(1);
            checks++;
            if (lvl_rd_data !== 16'hFFFF || vec_valid !== 1'b0 || nest_depth !== 3'd0) begin
                bad++;
                $display("FAIL R1 act rd=%h v=%0b d=%0d exp rd=ffff v=0 d=0",
                         lvl_rd_data, vec_valid, nest_depth);
            end
        end
        // R2: only dead slots request
        tag = "R2"; gie = 1; ctrl_en = 1; irq_req = 32'hFFC0_0000; step(4);
        // R3: global enable low
        tag = "R3"; gie = 0; irq_req = 32'h003F_FFFF; step(4);
        // R10: level register writes
        tag = "R10";
        wr_lvl(2'd0, 16'h1B1B); wr_lvl(2'd1, 16'hE4E4); wr_lvl(2'd2, 16'h0123);
        for (int k = 0; k < 4; k++) begin lvl_rd_sel = 2'(k); step(1); end
        // R4: mixed levels
        tag = "R4"; gie = 1;
        irq_req = 32'h0000_0003; step(2);
        irq_req = 32'h0000_0F0F; step(2);
        irq_req = 32'h0030_0100; step(2);
        irq_req = 32'h003F_FFFF; step(2);
        // R5: all equal level, ties by slot
        tag = "R5";
        for (int k = 0; k < 4; k++) wr_lvl(2'(k), 16'h5555);
        irq_req = 32'h0000_0105; step(2);
        irq_req = 32'h0020_0001; step(2);
        // R7: push then pop
        tag = "R7";
        irq_req = 32'h0000_0100; step(1);
        pulse_ack(); irq_req = 0; step(2);
        pulse_ret(); step(1);
        // R6 / R9: level ladder 0..3 on slots 0..3
        tag = "R6";
        wr_lvl(2'd0, 16'h00E4);
        irq_req = 32'h0000_0002; step(2); pulse_ack();
        irq_req = 32'h0000_0003; step(3);
        irq_req = 32'h0000_0004; step(2); pulse_ack();
        irq_req = 32'h0000_0007; step(3);
        pulse_ret(); pulse_ret();
        tag = "R9";
        irq_req = 32'h0000_0001; step(2); pulse_ack();
        irq_req = 32'h0000_0002; step(2); pulse_ack();
        irq_req = 32'h0000_0004; step(2); pulse_ack();
        irq_req = 32'h0000_0008; step(2); pulse_ack();
        irq_req = 32'h0000_000F; ctrl_en = 0; step(3);
        pulse_ack();
        irq_ack = 1; irq_ret = 1; step(1); irq_ack = 0; irq_ret = 0; step(1);
        ctrl_en = 1;
        repeat (4) pulse_ret();
        irq_req = 0; step(2); pulse_ack();
        // R8: controller off, slot order only
        tag = "R8"; ctrl_en = 0;
        irq_req = 32'h0000_000F; step(2);
        irq_req = 32'h0010_0001; step(2); pulse_ack();
        irq_req = 32'h0000_0011; step(2); pulse_ack();
        pulse_ret(); pulse_ret();
        // R11: random mix
        tag = "R11";
        for (int n = 0; n < 4000; n++) begin
            irq_req   = $urandom;
            gie       = ($urandom % 8) != 0;
            ctrl_en   = ($urandom % 4) != 0;
            irq_ack   = ($urandom % 3) == 0;
            irq_ret   = ($urandom % 5) == 0;
            lvl_wr_en = ($urandom % 6) == 0;
            lvl_wr_sel  = 2'($urandom);
            lvl_wr_data = 16'($urandom);
            lvl_rd_sel  = 2'($urandom);
            step(1);
        end
        irq_ack = 0; irq_ret = 0; lvl_wr_en = 0;
        step(2);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule